// File: doc/BRIEF.md
# LFSR-Sequenced Video Timing Generator

This block produces the raster timing for a display pipe: horizontal and vertical sync, a display-enable window, end-of-line and end-of-frame strobes, and the coordinates of the active pixel. Binary counters are not used for the horizontal and vertical positions. Both positions are held in 16-bit linear-feedback shift registers. An LFSR has only one XOR level in its next-state path, whatever the length of the count, so the counter logic stays shallow. Because of this, every compare point is programmed as an LFSR state and not as a count: the state reached after stepping n times from the all-ones home state stands for count n.

Software first writes ten comparison registers one byte at a time, while `run` is low. It then raises `run`, and the raster starts at count 0 in that same cycle. The companion module `vtg_count_conv` converts a binary count into its LFSR state by stepping the sequence that many times. The bench uses it to produce the register values. It is a separate module and is not instantiated inside the top.

Top module: `lfsr_video_timing`

## Requirements
- R1: While `run` is low, both position registers rest at 0xFFFF and every output (`hsync`, `vsync`, `de`, `eol`, `eof`, `pix_x`, `pix_y`) is 0. The cycle in which `run` is first seen high is horizontal count 0 of vertical count 0.
- R2: A position register steps by shifting left one place, and the XOR of old bits 15, 4, 2 and 1 fills the freed bit 0. Count n is the state after n such steps from 0xFFFF.
- R3: There are ten 16-bit compare registers, each reset to 0xFFFF. Each is written one byte per cycle with `cfg_we`: the upper byte at a base address and the lower byte at base+1. The base addresses are: line-last 0x09, frame-last 0x11, hsync-on 0x0B, hsync-off 0x0D, vsync-on 0x13, vsync-off 0x15, horizontal active-on 0x01, horizontal active-off 0x03, vertical active-on 0x05, vertical active-off 0x07.
- R4: When the horizontal state equals line-last (count H), `eol` is high for that cycle and the horizontal register then returns to 0xFFFF. A line is therefore H+1 cycles long.
- R5: The vertical register steps once per `eol`. When it holds frame-last (count V), the `eol` cycle of that line also raises `eof`, and the vertical register then returns to 0xFFFF. A frame is therefore V+1 lines.
- R6: `hsync` is high from the cycle whose horizontal state equals hsync-on up to, but not including, the cycle that equals hsync-off. If off equals on, or off is not met before the line ends, `hsync` stays high until the end of the line.
- R7: `vsync` follows the same window rule as R6, on whole lines: it starts at the line equal to vsync-on and ends before the line equal to vsync-off, or at the end of the frame.
- R8: `de` is high exactly when the horizontal window (active-on/off, R6 rule) and the vertical window (R7 rule) are both open.
- R9: While `de` is high, `pix_x` equals the horizontal count minus the active-on count and `pix_y` equals the vertical count minus the vertical active-on count. Both are 0 while `de` is low.
- R10: In the helper, a `start` pulse with count n makes `done` high for one cycle, n+1 cycles after the cycle in which `start` was sampled. `value` then holds the LFSR state for count n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Timing enable; low holds both positions at home |
| cfg_we | input | 1 | Byte write strobe for the compare registers |
| cfg_addr | input | ADDR_W | Byte address of the write |
| cfg_wdata | input | 8 | Byte written |
| hsync | output | 1 | Horizontal sync window |
| vsync | output | 1 | Vertical sync window |
| de | output | 1 | Display enable |
| eol | output | 1 | Last cycle of a line |
| eof | output | 1 | Last cycle of a frame |
| pix_x | output | COORD_W | Active pixel column |
| pix_y | output | COORD_W | Active pixel row |

## Verification
The assertions assume that the compare registers are rewritten only while `run` is low. They also assume that every programmed line and frame length is far shorter than the LFSR period, so that a state never repeats inside a line or frame. The stimulus follows both rules: it writes all registers with `run` low and draws line totals below 65 and frame totals below 14 lines. Window positions are drawn inside the totals, with a few directed cases that place an off point at, after or before its on point.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   localparam int LFSR_W = 16;
   localparam int N_CMP  = 10;
   localparam logic [LFSR_W-1:0] LFSR_HOME = 16'hFFFF;

   // compare register slots; each window keeps its off slot right after its on slot
   localparam int CMP_HACT_ON   = 0;
   localparam int CMP_HACT_OFF  = 1;
   localparam int CMP_VACT_ON   = 2;
   localparam int CMP_VACT_OFF  = 3;
   localparam int CMP_HLAST     = 4;
   localparam int CMP_HSYNC_ON  = 5;
   localparam int CMP_HSYNC_OFF = 6;
   localparam int CMP_VLAST     = 7;
   localparam int CMP_VSYNC_ON  = 8;
   localparam int CMP_VSYNC_OFF = 9;

   typedef logic [N_CMP-1:0][LFSR_W-1:0] cmp_bank_t;

   function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
      return {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
   endfunction

   // byte base address of a slot: slots 0..6 at odd addresses from 1, the rest from 0x11
   function automatic int unsigned cmp_base(input int unsigned idx);
      return (idx < 7) ? (1 + 2 * idx) : (17 + 2 * (idx - 7));
   endfunction
endpackage

// File: rtl/vtg_count_conv.sv
module vtg_count_conv
   import vtg_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic [CNT_W-1:0]     count,
   output logic                 busy,
   output logic                 done,
   output logic [LFSR_W-1:0]    value
);
   logic [LFSR_W-1:0] walk_q;
   logic [CNT_W-1:0]  left_q;

   if (CNT_W < 1 || CNT_W > 32) begin : g_chk_w
      $error("vtg_count_conv: CNT_W out of range");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         walk_q <= LFSR_HOME;
         left_q <= '0;
         value  <= LFSR_HOME;
      end else begin
         done <= 1'b0;
         if (start) begin
            walk_q <= LFSR_HOME;
            left_q <= count;
            busy   <= 1'b1;
         end else if (busy) begin
            if (left_q == '0) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               value <= walk_q;
            end else begin
               walk_q <= lfsr_next(walk_q);
               left_q <= left_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/vtg_cmp_regs.sv
module vtg_cmp_regs
   import vtg_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter bit MSB_AT_BASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output cmp_bank_t         bank
);
   localparam int HI_OFS = MSB_AT_BASE ? 0 : 1;
   localparam int LO_OFS = 1 - HI_OFS;

   if (ADDR_W < 5) begin : g_chk_addr
      $error("vtg_cmp_regs: ADDR_W too small for the register map");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N_CMP; i++) bank[i] <= LFSR_HOME;
      end else if (we) begin
         for (int i = 0; i < N_CMP; i++) begin
            if (addr == ADDR_W'(cmp_base(i) + HI_OFS)) bank[i][15:8] <= wdata;
            if (addr == ADDR_W'(cmp_base(i) + LO_OFS)) bank[i][7:0]  <= wdata;
         end
      end
   end
endmodule

// File: rtl/vtg_lfsr_axis.sv
module vtg_lfsr_axis
   import vtg_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   input  logic              adv,
   input  logic [LFSR_W-1:0] last_val,
   output logic [LFSR_W-1:0] state,
   output logic              wrap
);
   assign wrap = run & adv & (state == last_val);

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         state <= LFSR_HOME;
      end else if (adv) begin
         state <= wrap ? LFSR_HOME : lfsr_next(state);
      end
   end
endmodule

// File: rtl/vtg_window.sv
module vtg_window
   import vtg_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   input  logic              clr,
   input  logic [LFSR_W-1:0] state,
   input  logic [LFSR_W-1:0] on_val,
   input  logic [LFSR_W-1:0] off_val,
   output logic              act
);
   logic open_q;
   logic hit_on;
   logic hit_off;

   assign hit_on  = (state == on_val);
   assign hit_off = (state == off_val);
   assign act     = run & (hit_on | (open_q & ~hit_off));

   always_ff @(posedge clk) begin
      if (rst || !run) open_q <= 1'b0;
      else             open_q <= clr ? 1'b0 : act;
   end
endmodule

// File: rtl/lfsr_video_timing.sv
module lfsr_video_timing
   import vtg_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int COORD_W     = 12,
   parameter bit MSB_AT_BASE = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               run,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [7:0]         cfg_wdata,
   output logic               hsync,
   output logic               vsync,
   output logic               de,
   output logic               eol,
   output logic               eof,
   output logic [COORD_W-1:0] pix_x,
   output logic [COORD_W-1:0] pix_y
);
   localparam int N_WIN = 4;

   if (LFSR_W != 16) begin : g_chk_lfsr
      $error("lfsr_video_timing: feedback taps assume a 16-bit sequence");
   end
   if (COORD_W < 1 || COORD_W > LFSR_W) begin : g_chk_coord
      $error("lfsr_video_timing: COORD_W out of range");
   end

   cmp_bank_t         bank;
   logic [LFSR_W-1:0] h_state;
   logic [LFSR_W-1:0] v_state;
   logic              h_wrap;
   logic              v_wrap;
   logic [N_WIN-1:0]  win_act;
   logic              h_de;
   logic              v_de;
   logic [COORD_W-1:0] x_q;
   logic [COORD_W-1:0] y_q;

   vtg_cmp_regs #(.ADDR_W(ADDR_W), .MSB_AT_BASE(MSB_AT_BASE)) u_regs (
      .clk   (clk),
      .rst   (rst),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .bank  (bank)
   );

   vtg_lfsr_axis u_hax (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .adv      (1'b1),
      .last_val (bank[CMP_HLAST]),
      .state    (h_state),
      .wrap     (h_wrap)
   );

   vtg_lfsr_axis u_vax (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .adv      (h_wrap),
      .last_val (bank[CMP_VLAST]),
      .state    (v_state),
      .wrap     (v_wrap)
   );

   // window 0: hsync, 1: horizontal active, 2: vsync, 3: vertical active
   for (genvar w = 0; w < N_WIN; w++) begin : g_win
      localparam bit VERT   = (w >= 2);
      localparam int ON_IDX = (w == 0) ? CMP_HSYNC_ON :
                              (w == 1) ? CMP_HACT_ON  :
                              (w == 2) ? CMP_VSYNC_ON : CMP_VACT_ON;
      vtg_window u_win (
         .clk     (clk),
         .rst     (rst),
         .run     (run),
         .clr     (VERT ? v_wrap  : h_wrap),
         .state   (VERT ? v_state : h_state),
         .on_val  (bank[ON_IDX]),
         .off_val (bank[ON_IDX + 1]),
         .act     (win_act[w])
      );
   end

   assign hsync = win_act[0];
   assign h_de  = win_act[1];
   assign vsync = win_act[2];
   assign v_de  = win_act[3];
   assign de    = h_de & v_de;
   assign eol   = h_wrap;
   assign eof   = v_wrap;

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         x_q <= '0;
         y_q <= '0;
      end else begin
         x_q <= h_wrap ? '0 : (h_de ? x_q + 1'b1 : '0);
         if (h_wrap) y_q <= v_wrap ? '0 : (v_de ? y_q + 1'b1 : '0);
      end
   end

   assign pix_x = de ? x_q : '0;
   assign pix_y = de ? y_q : '0;
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
   import vtg_pkg::*;
#(
   parameter int COORD_W = 12
) (
   input logic               clk,
   input logic               rst,
   input logic               run,
   input logic               eol,
   input logic               eof,
   input logic               de,
   input logic               hsync,
   input logic               vsync,
   input logic [LFSR_W-1:0]  h_state,
   input logic [LFSR_W-1:0]  v_state,
   input logic [LFSR_W-1:0]  hs_on,
   input logic [LFSR_W-1:0]  vs_on,
   input logic [COORD_W-1:0] pix_x
);
   AST_IDLE_HOME: assert property (@(posedge clk) disable iff (rst)
      !run |=> (h_state == LFSR_HOME && v_state == LFSR_HOME)); // R1
   AST_H_STEP: assert property (@(posedge clk) disable iff (rst)
      (run && !eol) |=> (!run || h_state == lfsr_next($past(h_state)))); // R2
   AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
      (run && eol) |=> (!run || h_state == LFSR_HOME)); // R4
   AST_V_HOLD: assert property (@(posedge clk) disable iff (rst)
      (run && !eol) |=> (!run || $stable(v_state))); // R5
   AST_EOF_ON_EOL: assert property (@(posedge clk) disable iff (rst)
      eof |-> eol); // R5
   AST_HSYNC_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(hsync) |-> (h_state == hs_on)); // R6
   AST_VSYNC_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(vsync) |-> (v_state == vs_on)); // R7
   AST_X_STEP: assert property (@(posedge clk) disable iff (rst)
      (de && !eol) |=> (!de || pix_x == COORD_W'($past(pix_x) + 1'b1))); // R9
endmodule

bind lfsr_video_timing vtg_chk #(.COORD_W(COORD_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .run     (run),
   .eol     (eol),
   .eof     (eof),
   .de      (de),
   .hsync   (hsync),
   .vsync   (vsync),
   .h_state (h_state),
   .v_state (v_state),
   .hs_on   (bank[vtg_pkg::CMP_HSYNC_ON]),
   .vs_on   (bank[vtg_pkg::CMP_VSYNC_ON]),
   .pix_x   (pix_x)
);

// File: tb/sim_lfsr_video_timing.sv
`timescale 1ns/1ps
module sim_lfsr_video_timing;
   localparam int ADDR_W  = 8;
   localparam int COORD_W = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic run = 1'b0;
   logic cfg_we = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic hsync, vsync, de, eol, eof;
   logic [COORD_W-1:0] pix_x, pix_y;

   logic conv_start = 1'b0;
   logic [15:0] conv_count = '0;
   logic conv_busy, conv_done;
   logic [15:0] conv_value;

   int n_chk = 0;
   int n_err = 0;
   bit ended = 1'b0;

   // mode, in binary counts
   int ht, ve, hsw, vsw, xs, xe, ys, ye;

   always #2 clk = ~clk;

   lfsr_video_timing #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u0 (
      .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .de(de), .eol(eol),
      .eof(eof), .pix_x(pix_x), .pix_y(pix_y)
   );

   vtg_count_conv #(.CNT_W(16)) u_conv (
      .clk(clk), .rst(rst), .start(conv_start), .count(conv_count),
      .busy(conv_busy), .done(conv_done), .value(conv_value)
   );

   function automatic logic [15:0] ref_lfsr(input int n);
      logic [15:0] lv = 16'hFFFF;
      for (int i = 0; i < n; i++) lv = {lv[14:0], lv[15] ^ lv[4] ^ lv[2] ^ lv[1]};
      return lv;
   endfunction

   function automatic bit ref_win(input int n, input int s, input int e);
      return (n >= s) && (e <= s || n < e);
   endfunction

   task automatic report();
      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_idle(input string when);
      check({hsync, vsync, de, eol, eof} == 5'b0 && pix_x == '0 && pix_y == '0,
            "R1", when, int'({hsync, vsync, de, eol, eof}), 0);
   endtask

   // R10: helper latency and result
   task automatic convert(input int n, output logic [15:0] v);
      int cyc;
      @(negedge clk);
      conv_start = 1'b1;
      conv_count = 16'(n);
      @(negedge clk);
      conv_start = 1'b0;
      cyc = 1;
      while (!conv_done && cyc < 70000) begin
         @(negedge clk);
         cyc++;
      end
      check(cyc == n + 2, "R10", "done latency", cyc, n + 2);
      check(conv_value == ref_lfsr(n), "R10", "converted value",
            int'(conv_value), int'(ref_lfsr(n)));
      v = conv_value;
   endtask

   task automatic wr_byte(input int a, input logic [7:0] d);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = ADDR_W'(a);
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // R3: upper byte at the base, lower byte at base+1
   task automatic program_mode();
      int cnt [10];
      logic [15:0] v;
      int base;
      cnt[0] = xs;     cnt[1] = xe;      cnt[2] = ys;  cnt[3] = ye;
      cnt[4] = ht - 1; cnt[5] = 1;       cnt[6] = hsw + 1;
      cnt[7] = ve;     cnt[8] = 0;       cnt[9] = vsw;
      for (int i = 0; i < 10; i++) begin
         convert(cnt[i], v);
         base = (i < 7) ? 1 + 2 * i : 17 + 2 * (i - 7);
         wr_byte(base, v[15:8]);
         wr_byte(base + 1, v[7:0]);
      end
   endtask

   task automatic check_cycle(input int k);
      int h, v, px, py;
      bit e_eol, e_eof, e_hs, e_vs, e_de;
      h = k % ht;
      v = (k / ht) % (ve + 1);
      e_eol = (h == ht - 1);
      e_eof = e_eol && (v == ve);
      e_hs  = ref_win(h, 1, hsw + 1);
      e_vs  = ref_win(v, 0, vsw);
      e_de  = ref_win(h, xs, xe) && ref_win(v, ys, ye);
      px = e_de ? h - xs : 0;
      py = e_de ? v - ys : 0;
      check(eol == e_eol, "R2 R4", "eol", int'(eol), int'(e_eol));
      check(eof == e_eof, "R5", "eof", int'(eof), int'(e_eof));
      check(hsync == e_hs, "R3 R6", "hsync", int'(hsync), int'(e_hs));
      check(vsync == e_vs, "R7", "vsync", int'(vsync), int'(e_vs));
      check(de == e_de, "R8", "de", int'(de), int'(e_de));
      check(int'(pix_x) == px, "R9", "pix_x", int'(pix_x), px);
      check(int'(pix_y) == py, "R9", "pix_y", int'(pix_y), py);
   endtask

   task automatic run_cycles(input int ncyc);
      @(negedge clk);
      run = 1'b1;
      for (int k = 0; k < ncyc; k++) begin
         #1;
         check_cycle(k);
         @(negedge clk);
      end
      run = 1'b0;
      #1;
      check_idle("outputs after run falls");
   endtask

   task automatic run_mode();
      program_mode();
      run_cycles(2 * ht * (ve + 1) + 3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      report();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      #1;
      check_idle("after reset");

      // R8 R9: full-line, full-frame window starting at count 0
      ht = 20; hsw = 2; xs = 0; xe = 20; ve = 4; vsw = 1; ys = 0; ye = 5;
      run_mode();

      // R6 R8: off before on (horizontal) and off equal to on (vertical)
      ht = 30; hsw = 3; xs = 12; xe = 5; ve = 6; vsw = 2; ys = 2; ye = 2;
      run_mode();

      // R1: stop mid-frame, then restart from count 0
      ht = 26; hsw = 2; xs = 6; xe = 22; ve = 5; vsw = 1; ys = 1; ye = 5;
      program_mode();
      run_cycles(37);
      run_cycles(ht * (ve + 1) + 2);

      for (int m = 0; m < 8; m++) begin
         ht  = 24 + int'($urandom % 41);
         hsw = 1 + int'($urandom % 4);
         xs  = hsw + 2 + int'($urandom % (ht - hsw - 10));
         xe  = xs + 1 + int'($urandom % (ht - xs));
         ve  = 5 + int'($urandom % 8);
         vsw = 1 + int'($urandom % 2);
         ys  = vsw + int'($urandom % (ve - vsw - 1));
         ye  = ys + 1 + int'($urandom % (ve + 1 - ys));
         run_mode();
      end

      report();
   end
endmodule